// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block collects one-cycle interrupt pulses from a group of maskable sources and a small group of trap sources. It holds each pulse as a pending bit. It then picks one pending source to present to the processor. Each maskable source carries a two-bit priority that is programmed by software. The priority either takes the source out of arbitration or places it at level 1, 2 or 3. Level 3 ranks highest. The trap sources always compete at level 3, and their programmed priority plays no part.

A single global enable gates the maskable sources. Trap sources are presented to the processor whether or not the global enable is set. Several events change the enable: an acknowledge, a trap execution or a disable strobe clears it, and a return-from-interrupt strobe sets it. A direct software write can force it either way.

The processor samples a registered request line and a registered winner index. When it acknowledges, the controller drops the pending bit of the source it was presenting.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on any source sets that source's pending bit at the next clock edge.
  - The pending vector maps trap source t to bit t.
  - It maps maskable source j to bit NTRAP+j.
  - The winner index uses the same numbering.
- R2: Maskable source j takes its priority from bits [2j+1:2j] of the priority word. The codes are:
  - 00: disabled. The pending bit still latches, but the source never wins arbitration.
  - 01, 10 and 11: levels 1, 2 and 3.
- R3: Any eligible source at a higher level wins over every eligible source at a lower level.
- R4: Among eligible sources at the same level, the source with the lowest index wins. Trap sources compete at level 3 and hold the lowest indices.
- R5: The request output may be high only in one of two cases:
  - A trap source is pending.
  - The global enable is set and at least one maskable source with a nonzero priority is pending.
- R6: An acknowledge while the request output is high clears the pending bit of the presented index. A pulse on that same source in the same cycle leaves the bit set.
- R7: A request-register write clears each maskable pending bit whose data bit is 0 and leaves bits written 1 unchanged. A same-cycle pulse on a source keeps that source's bit set.
- R8: The global enable becomes 0 after any of the following, unless a write to the enable register occurs in the same cycle:
  - an acknowledge
  - a disable strobe
  - a trap-execution strobe
  - reset
- R9: The global enable becomes 1 after a return strobe, provided no clearing strobe and no write to the enable register occur in the same cycle. An enable write always takes precedence and loads its data bit.
- R10: The request output and the winner index are registered. They reflect the pending, priority and enable state that was loaded at the same clock edge. After reset the pending bits, request, index and enable all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NSRC | One-cycle pulses from maskable sources |
| trap_pulse | input | NTRAP | One-cycle pulses from forced level-3 trap sources |
| wr_req | input | 1 | Write strobe for the maskable pending bits |
| wr_req_data | input | NSRC | Write data; 0 clears a bit |
| wr_prio | input | 1 | Write strobe for the priority word |
| wr_prio_data | input | 2*NSRC | Two priority bits per maskable source |
| wr_ie | input | 1 | Write strobe for the global enable |
| wr_ie_data | input | 1 | Value written to the global enable |
| ack | input | 1 | Processor acknowledge of the presented request |
| iret | input | 1 | Return-from-interrupt strobe |
| di | input | 1 | Disable-interrupts strobe |
| trap_exec | input | 1 | Trap-execution strobe |
| irq_out | output | 1 | Registered request to the processor |
| irq_idx | output | $clog2(NSRC+NTRAP) | Registered index of the winning source |
| ie_out | output | 1 | Current global enable |
| pend_out | output | NSRC+NTRAP | Current pending bits |

## Verification
The hardest case to reach is a collision at a single bit: a new pulse lands in the same cycle as an acknowledge or a software clear of that bit. Random stimulus alone rarely lines these up. Directed steps therefore pulse a trap while acknowledging it, and write a clear mask alongside a pulse on one of the masked sources. A second hard case is a trap arriving while the global enable is off, so that maskable requests are still pending. Directed steps disable the enable first and then pulse a trap. The random phase then runs a per-cycle bench model against long mixed sequences of pulses, writes and strobes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        LVL_OFF = 2'b00,
        LVL_1   = 2'b01,
        LVL_2   = 2'b10,
        LVL_3   = 2'b11
    } lvl_e;
endpackage

// File: rtl/irq_lvl_map.sv
module irq_lvl_map
    import irq_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int NTRAP = 3,
    localparam int N    = NSRC + NTRAP
) (
    input  logic [N-1:0]      pend,
    input  logic [2*NSRC-1:0] prio,
    input  logic              ie,
    output logic [N-1:0]      elig3,
    output logic [N-1:0]      elig2,
    output logic [N-1:0]      elig1
);
    // Trap sources always sit at the top level, independent of the enable.
    for (genvar t = 0; t < NTRAP; t++) begin : g_trap
        assign elig3[t] = pend[t];
        assign elig2[t] = 1'b0;
        assign elig1[t] = 1'b0;
    end

    // Maskable sources compete only while enabled and not set to off.
    for (genvar j = 0; j < NSRC; j++) begin : g_mask
        lvl_e lv;
        assign lv = lvl_e'(prio[2*j +: 2]);
        assign elig3[NTRAP+j] = pend[NTRAP+j] && ie && (lv == LVL_3);
        assign elig2[NTRAP+j] = pend[NTRAP+j] && ie && (lv == LVL_2);
        assign elig1[NTRAP+j] = pend[NTRAP+j] && ie && (lv == LVL_1);
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 19,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Lowest set index wins.
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC  = 16,
    parameter int NTRAP = 3,
    localparam int N    = NSRC + NTRAP,
    localparam int IW   = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_pulse,
    input  logic [NTRAP-1:0]  trap_pulse,
    input  logic              wr_req,
    input  logic [NSRC-1:0]   wr_req_data,
    input  logic              wr_prio,
    input  logic [2*NSRC-1:0] wr_prio_data,
    input  logic              wr_ie,
    input  logic              wr_ie_data,
    input  logic              ack,
    input  logic              iret,
    input  logic              di,
    input  logic              trap_exec,
    output logic              irq_out,
    output logic [IW-1:0]     irq_idx,
    output logic              ie_out,
    output logic [N-1:0]      pend_out
);
    typedef struct packed {
        logic [N-1:0]      pend;
        logic [2*NSRC-1:0] prio;
        logic              ie;
        logic              irq;
        logic [IW-1:0]     idx;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]      pend_nx;
    logic [2*NSRC-1:0] prio_nx;
    logic              ie_nx;

    // Next pending, priority and enable values.
    always_comb begin
        pend_nx = s_q.pend;
        if (wr_req) begin
            for (int j = 0; j < NSRC; j++) begin
                if (!wr_req_data[j]) pend_nx[NTRAP+j] = 1'b0;
            end
        end
        if (ack && s_q.irq) pend_nx[s_q.idx] = 1'b0;
        // A new pulse wins over any clear in the same cycle.
        pend_nx = pend_nx | {src_pulse, trap_pulse};

        prio_nx = wr_prio ? wr_prio_data : s_q.prio;

        ie_nx = s_q.ie;
        if (wr_ie)                         ie_nx = wr_ie_data;
        else if (ack || di || trap_exec)   ie_nx = 1'b0;
        else if (iret)                     ie_nx = 1'b1;
    end

    logic [N-1:0]  elig [3];
    logic [2:0]    hit;
    logic [IW-1:0] pidx [3];

    irq_lvl_map #(.NSRC(NSRC), .NTRAP(NTRAP)) u_map (
        .pend  (pend_nx),
        .prio  (prio_nx),
        .ie    (ie_nx),
        .elig3 (elig[2]),
        .elig2 (elig[1]),
        .elig1 (elig[0])
    );

    for (genvar lv = 0; lv < 3; lv++) begin : g_pick
        irq_pick #(.N(N), .IW(IW)) u_pick (
            .req (elig[lv]),
            .hit (hit[lv]),
            .idx (pidx[lv])
        );
    end

    // Assemble the registered next state; higher level first.
    always_comb begin
        s_d.pend = pend_nx;
        s_d.prio = prio_nx;
        s_d.ie   = ie_nx;
        s_d.irq  = |hit;
        if (hit[2])      s_d.idx = pidx[2];
        else if (hit[1]) s_d.idx = pidx[1];
        else if (hit[0]) s_d.idx = pidx[0];
        else             s_d.idx = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_out  = s_q.irq;
    assign irq_idx  = s_q.idx;
    assign ie_out   = s_q.ie;
    assign pend_out = s_q.pend;
endmodule

// File: rtl/irq_chk.sv
module irq_chk #(
    parameter int NSRC  = 16,
    parameter int NTRAP = 3,
    localparam int N    = NSRC + NTRAP,
    localparam int IW   = $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_pulse,
    input logic [NTRAP-1:0]  trap_pulse,
    input logic              wr_req,
    input logic [NSRC-1:0]   wr_req_data,
    input logic              wr_prio,
    input logic [2*NSRC-1:0] wr_prio_data,
    input logic              wr_ie,
    input logic              wr_ie_data,
    input logic              ack,
    input logic              iret,
    input logic              di,
    input logic              trap_exec,
    input logic              irq_out,
    input logic [IW-1:0]     irq_idx,
    input logic              ie_out,
    input logic [N-1:0]      pend_out
);
    logic [N-1:0] pulses;
    assign pulses = {src_pulse, trap_pulse};

    assert_pulse_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != '0) |=> ((pend_out & $past(pulses)) == $past(pulses)));

    assert_winner_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pend_out[irq_idx]);

    assert_trap_only_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ie_out) |-> (irq_idx < IW'(NTRAP)));

    assert_idle_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_out == '0) |-> !irq_out);

    assert_ack_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack || di || trap_exec) && !wr_ie) |=> !ie_out);

    assert_return_sets_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iret && !ack && !di && !trap_exec && !wr_ie) |=> ie_out);

    assert_write_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ie |=> (ie_out == $past(wr_ie_data)));
endmodule

bind prio_irq_ctrl irq_chk #(.NSRC(NSRC), .NTRAP(NTRAP)) u_chk (.*);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
    localparam int NSRC  = 16;
    localparam int NTRAP = 3;
    localparam int N     = NSRC + NTRAP;
    localparam int IW    = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   srcp = '0;
    logic [NTRAP-1:0]  trapp = '0;
    logic              wr_req = 1'b0;
    logic [NSRC-1:0]   wr_req_data = '0;
    logic              wr_prio = 1'b0;
    logic [2*NSRC-1:0] wr_prio_data = '0;
    logic              wr_ie = 1'b0;
    logic              wr_ie_data = 1'b0;
    logic              ack = 1'b0, iret = 1'b0, di = 1'b0, trap_exec = 1'b0;
    logic              irq_out;
    logic [IW-1:0]     irq_idx;
    logic              ie_out;
    logic [N-1:0]      pend_out;

    int errs = 0;
    int checks = 0;

    logic [N-1:0]      m_pend = '0;
    logic [2*NSRC-1:0] m_prio = '0;
    logic              m_ie = 1'b0;
    logic              m_irq = 1'b0;
    int                m_idx = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.NSRC(NSRC), .NTRAP(NTRAP)) u0 (
        .clk(clk), .rst_n(rst_n), .src_pulse(srcp), .trap_pulse(trapp),
        .wr_req(wr_req), .wr_req_data(wr_req_data), .wr_prio(wr_prio),
        .wr_prio_data(wr_prio_data), .wr_ie(wr_ie), .wr_ie_data(wr_ie_data),
        .ack(ack), .iret(iret), .di(di), .trap_exec(trap_exec),
        .irq_out(irq_out), .irq_idx(irq_idx), .ie_out(ie_out), .pend_out(pend_out)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference update following the requirements.
    task automatic model_step();
        logic [N-1:0] p;
        logic         e;
        p = m_pend;
        if (wr_req)
            for (int j = 0; j < NSRC; j++) if (!wr_req_data[j]) p[NTRAP+j] = 1'b0;
        if (ack && m_irq) p[m_idx] = 1'b0;
        p = p | {srcp, trapp};
        if (wr_prio) m_prio = wr_prio_data;
        if (wr_ie) m_ie = wr_ie_data;
        else if (ack || di || trap_exec) m_ie = 1'b0;
        else if (iret) m_ie = 1'b1;
        m_pend = p;
        m_irq = 1'b0;
        m_idx = 0;
        for (int lv = 3; lv >= 1; lv--) begin
            for (int i = 0; i < N; i++) begin
                if (i < NTRAP) e = (lv == 3);
                else e = m_ie && (m_prio[2*(i-NTRAP) +: 2] == 2'(lv));
                if (!m_irq && p[i] && e) begin
                    m_irq = 1'b1;
                    m_idx = i;
                end
            end
        end
    endtask

    task automatic clear_inputs();
        srcp = '0; trapp = '0; wr_req = 1'b0; wr_req_data = '0;
        wr_prio = 1'b0; wr_prio_data = '0; wr_ie = 1'b0; wr_ie_data = 1'b0;
        ack = 1'b0; iret = 1'b0; di = 1'b0; trap_exec = 1'b0;
    endtask

    // One clock: model update at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R1 pending vector", int'(pend_out), int'(m_pend));
        chk("R3 request line", int'(irq_out), int'(m_irq));
        chk("R4 winner index", int'(irq_idx), m_idx);
        chk("R8 global enable", int'(ie_out), int'(m_ie));
        clear_inputs();
    endtask

    initial begin
        #2000000;
        errs++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset pend", int'(pend_out), 0);
        chk("R10 reset irq", int'(irq_out), 0);
        chk("R10 reset ie", int'(ie_out), 0);
        chk("R10 reset idx", int'(irq_idx), 0);

        // src3 level1, src5 level2, src6 level2, others off; enable on.
        wr_prio = 1'b1;
        wr_prio_data = '0;
        wr_prio_data[7:6]   = 2'b01;
        wr_prio_data[11:10] = 2'b10;
        wr_prio_data[13:12] = 2'b10;
        wr_ie = 1'b1; wr_ie_data = 1'b1;
        tick();
        chk("R9 write enable", int'(ie_out), 1);

        srcp[3] = 1'b1; tick();
        chk("R1 level1 presented", int'(irq_idx), NTRAP + 3);
        chk("R10 same-edge request", int'(irq_out), 1);
        srcp[5] = 1'b1; tick();
        chk("R3 level2 over level1", int'(irq_idx), NTRAP + 5);
        srcp[6] = 1'b1; tick();
        chk("R4 lower index wins tie", int'(irq_idx), NTRAP + 5);
        srcp[7] = 1'b1; tick();
        chk("R2 disabled still latched", int'(pend_out[NTRAP+7]), 1);
        chk("R2 disabled not chosen", int'(irq_idx), NTRAP + 5);

        ack = 1'b1; tick();
        chk("R6 ack clears presented", int'(pend_out[NTRAP+5]), 0);
        chk("R8 ack clears enable", int'(ie_out), 0);
        chk("R5 masked while disabled", int'(irq_out), 0);

        trapp[2] = 1'b1; tick();
        chk("R5 trap despite enable off", int'(irq_out), 1);
        chk("R5 trap index", int'(irq_idx), 2);
        trapp[0] = 1'b1; ack = 1'b1; tick();
        chk("R6 ack removed trap2", int'(pend_out[2]), 0);
        chk("R4 trap0 now wins", int'(irq_idx), 0);
        trapp[0] = 1'b1; ack = 1'b1; tick();
        chk("R6 pulse beats ack", int'(pend_out[0]), 1);

        wr_req = 1'b1;
        wr_req_data = '1;
        wr_req_data[3] = 1'b0;
        wr_req_data[6] = 1'b0;
        srcp[6] = 1'b1;
        tick();
        chk("R7 write clears bit", int'(pend_out[NTRAP+3]), 0);
        chk("R7 pulse beats write", int'(pend_out[NTRAP+6]), 1);
        chk("R7 ones keep bit", int'(pend_out[NTRAP+7]), 1);

        iret = 1'b1; di = 1'b1; tick();
        chk("R9 clear beats return", int'(ie_out), 0);
        iret = 1'b1; tick();
        chk("R9 return sets enable", int'(ie_out), 1);
        trap_exec = 1'b1; tick();
        chk("R8 trap exec clears", int'(ie_out), 0);
        wr_ie = 1'b1; wr_ie_data = 1'b1; di = 1'b1; tick();
        chk("R9 write beats strobe", int'(ie_out), 1);
        di = 1'b1; tick();
        chk("R8 disable strobe", int'(ie_out), 0);

        // Random phase.
        for (int c = 0; c < 4000; c++) begin
            for (int j = 0; j < NSRC; j++) srcp[j] = ($urandom % 20) == 0;
            for (int t = 0; t < NTRAP; t++) trapp[t] = ($urandom % 60) == 0;
            if (($urandom % 25) == 0) begin
                wr_req = 1'b1;
                wr_req_data = NSRC'($urandom);
            end
            if (($urandom % 40) == 0) begin
                wr_prio = 1'b1;
                wr_prio_data = (2*NSRC)'($urandom);
            end
            if (($urandom % 30) == 0) begin
                wr_ie = 1'b1;
                wr_ie_data = 1'($urandom);
            end
            ack       = m_irq && (($urandom % 3) == 0);
            iret      = ($urandom % 6) == 0;
            di        = ($urandom % 25) == 0;
            trap_exec = ($urandom % 40) == 0;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule